// File: doc/BRIEF.md
# Next Program Counter Sequencer

This block keeps the program counter for a processor whose instructions are fixed 32-bit words aligned on 4-byte boundaries, and works out the next counter value on every clock. It reads only the 6-bit major opcode of the fetched word. From that opcode it picks one of three flows: step to the next word, a conditional branch relative to the next word, or a jump to an absolute target inside the current 256 MB region. The datapath supplies an equality flag that says whether the two compared registers are equal. The block builds the branch and jump targets itself.

Jump-and-link instructions also raise a strobe that carries a return address, which the datapath writes into the register file. A stall input freezes the counter. A synchronous reset loads a vector that is set by a parameter.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset loads the PC with parameter RESET_VECTOR (default 0x00000000).
- R2: When no branch or jump is taken, the next PC is the current PC plus 4. This covers opcode 0 (register format) and every opcode other than 2, 3, 4 and 5.
- R3: Opcode 4 (bits 31:26) is branch-on-equal. It is taken only when eqFlag is 1. The next PC is then PC+4 plus the sign-extended bits 15:0 multiplied by 4.
- R4: Opcode 5 is branch-on-not-equal. It is taken only when eqFlag is 0, and it uses the same target as R3.
- R5: The branch offset is two's complement, so negative offsets move backward. The extreme values 0x7FFF and 0x8000 reach +32767 and -32768 instructions from PC+4.
- R6: Opcode 2 (jump) and opcode 3 (jump-and-link) set the next PC to {PC+4 bits 31:28, instr bits 25:0, 2'b00}.
- R7: linkValid is 1 exactly when the opcode is 3 and stall is 0. linkAddr always equals pcPlus4.
- R8: While stall is 1, the PC keeps its value whatever the instruction and the flag.
- R9: pcPlus4 always equals pc + 4, and bits 1:0 of the PC are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold the PC |
| instr | input | 32 | Fetched instruction word |
| eqFlag | input | 1 | Compared registers are equal |
| pc | output | 32 | Current program counter |
| pcPlus4 | output | 32 | Address of the next sequential word |
| linkAddr | output | 32 | Return address for jump-and-link |
| linkValid | output | 1 | Return address is to be written |

## Verification
The assertions assume that reset is applied on the first clock. They also assume that RESET_VECTOR is word aligned, so alignment follows from the target arithmetic rather than from the inputs. The bench changes instr, eqFlag and stall only on the falling edge, so every input is stable at the rising edge. It covers every opcode of interest with both flag values, the offset extremes, stalls and resets in the middle of a run. Expected PCs come from an integer model kept in the bench.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int XLEN = 32;
  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JMP   = 6'd2;
  localparam logic [5:0] OP_JAL   = 6'd3;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;

  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'd0,
    FLOW_BR   = 2'd1,
    FLOW_JUMP = 2'd2
  } flow_e;

  typedef struct packed {
    flow_e flow;
    logic  hold;
    logic  link;
  } seq_ctrl_t;
endpackage

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
  import pc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stall,
  input  logic [5:0] opcode,
  input  logic       eqFlag,
  output seq_ctrl_t  ctrl
);
  always_comb begin
    ctrl.hold = stall;
    ctrl.link = 1'b0;
    ctrl.flow = FLOW_SEQ;
    if (!stall) begin
      unique case (opcode)
        OP_BEQ: if (eqFlag)  ctrl.flow = FLOW_BR;
        OP_BNE: if (!eqFlag) ctrl.flow = FLOW_BR;
        OP_JMP: ctrl.flow = FLOW_JUMP;
        OP_JAL: begin
          ctrl.flow = FLOW_JUMP;
          ctrl.link = 1'b1;
        end
        default: ctrl.flow = FLOW_SEQ;
      endcase
    end
  end

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    ctrl.hold |-> (ctrl.flow == FLOW_SEQ && !ctrl.link)); // R8
  AST_LINK_ONLY_JAL: assert property (@(posedge clk) disable iff (rst)
    ctrl.link |-> (opcode == OP_JAL && ctrl.flow == FLOW_JUMP)); // R7
  AST_BR_SENSE: assert property (@(posedge clk) disable iff (rst)
    (ctrl.flow == FLOW_BR) |-> ((opcode == OP_BEQ && eqFlag) || (opcode == OP_BNE && !eqFlag))); // R3
endmodule

// File: rtl/pc_seq_dp.sv
module pc_seq_dp
  import pc_seq_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VECTOR = '0,
  parameter int OFFSET_W = 16,
  parameter int INDEX_W  = 26
) (
  input  logic            clk,
  input  logic            rst,
  input  seq_ctrl_t       ctrl,
  input  logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] pcQ,
  output logic [XLEN-1:0] pcInc
);
  localparam int REGION_W = XLEN - INDEX_W - 2;

  logic [XLEN-1:0] brTarget;
  logic [XLEN-1:0] jmpTarget;
  logic [XLEN-1:0] pcNext;
  logic [XLEN-1:0] offsetExt;

  assign pcInc     = pcQ + XLEN'(4);
  assign offsetExt = {{(XLEN-OFFSET_W-2){instr[OFFSET_W-1]}}, instr[OFFSET_W-1:0], 2'b00};
  assign brTarget  = pcInc + offsetExt;
  assign jmpTarget = {pcInc[XLEN-1 -: REGION_W], instr[INDEX_W-1:0], 2'b00};

  always_comb begin
    unique case (ctrl.flow)
      FLOW_BR:   pcNext = brTarget;
      FLOW_JUMP: pcNext = jmpTarget;
      default:   pcNext = pcInc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             pcQ <= RESET_VECTOR;
    else if (!ctrl.hold) pcQ <= pcNext;
  end

  AST_RESET_LOAD: assert property (@(posedge clk)
    rst |=> (pcQ == RESET_VECTOR)); // R1
  AST_HOLD_PC: assert property (@(posedge clk) disable iff (rst)
    ctrl.hold |=> $stable(pcQ)); // R8
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.hold && ctrl.flow == FLOW_SEQ) |=> (pcQ == $past(pcQ) + 32'd4)); // R2
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    (ctrl.flow == FLOW_JUMP) |=> (pcQ[XLEN-1 -: REGION_W] == $past(pcInc[XLEN-1 -: REGION_W]))); // R6
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    pcQ[1:0] == 2'b00); // R9
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter logic [31:0] RESET_VECTOR = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stall,
  input  logic [31:0] instr,
  input  logic        eqFlag,
  output logic [31:0] pc,
  output logic [31:0] pcPlus4,
  output logic [31:0] linkAddr,
  output logic        linkValid
);
  seq_ctrl_t ctrl;

  pc_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .stall(stall),
    .opcode(instr[31:26]), .eqFlag(eqFlag), .ctrl(ctrl)
  );

  pc_seq_dp #(.RESET_VECTOR(RESET_VECTOR)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .instr(instr),
    .pcQ(pc), .pcInc(pcPlus4)
  );

  assign linkAddr  = pcPlus4;
  assign linkValid = ctrl.link;
endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        stall = 0;
  logic [31:0] instr = 0;
  logic        eqFlag = 0;
  logic [31:0] pc, pcPlus4, linkAddr;
  logic        linkValid;

  int nCmp = 0;
  int nBad = 0;
  longint unsigned modelPc = 0;

  always #2.5 clk = ~clk;

  pc_sequencer u_dut (
    .clk(clk), .rst(rst), .stall(stall), .instr(instr), .eqFlag(eqFlag),
    .pc(pc), .pcPlus4(pcPlus4), .linkAddr(linkAddr), .linkValid(linkValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply one cycle with the given inputs and update the behavioural model.
  task automatic step(input logic [5:0] op, input logic [25:0] rest, input logic eq,
                      input logic stl, input string req);
    longint unsigned nxt;
    int opi;
    int off;
    bit taken;
    instr = {op, rest};
    eqFlag = eq;
    stall = stl;
    #1;
    opi = int'(op);
    check("R9 pcPlus4", pcPlus4, 32'(modelPc + 4));
    check("R7 linkAddr", linkAddr, 32'(modelPc + 4));
    check("R7 linkValid", {31'd0, linkValid}, {31'd0, (opi == 3 && !stl)});
    nxt = modelPc + 4;
    if (!stl) begin
      if (opi == 4 || opi == 5) begin
        taken = (opi == 4) ? eq : !eq;
        off = int'($signed(rest[15:0]));
        if (taken) nxt = longint'(modelPc) + 4 + longint'(off) * 4;
      end else if (opi == 2 || opi == 3) begin
        nxt = ((modelPc + 4) & 64'hF000_0000) | (longint'(rest) * 4);
      end
      modelPc = nxt & 64'hFFFF_FFFF;
    end
    @(negedge clk);
    check(req, pc, 32'(modelPc));
    check("R9 align", {30'd0, pc[1:0]}, 32'd0);
  endtask

  task automatic doReset();
    rst = 1;
    @(negedge clk);
    rst = 0;
    modelPc = 0;
    check("R1 reset", pc, 32'h0);
  endtask

  initial begin
    #200000;
    nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    doReset();
    step(6'd0, 26'h12345, 0, 0, "R2 rtype");
    step(6'd9, 26'h0, 1, 0, "R2 other op");
    step(6'd4, 26'h0003, 1, 0, "R3 beq taken");
    step(6'd4, 26'h0003, 0, 0, "R3 beq not taken");
    step(6'd5, 26'h0010, 0, 0, "R4 bne taken");
    step(6'd5, 26'h0010, 1, 0, "R4 bne not taken");
    step(6'd4, 26'hFFFE, 1, 0, "R5 negative offset");
    step(6'd2, 26'h3FF_FFFF, 0, 0, "R6 jump max");
    step(6'd4, 26'h7FFF, 1, 0, "R5 max offset");
    step(6'd5, 26'h8000, 0, 0, "R5 min offset");
    step(6'd3, 26'h0000_100, 0, 0, "R6 jal");
    step(6'd3, 26'h0000_200, 0, 1, "R8 stall jal");
    step(6'd4, 26'h0040, 1, 1, "R8 stall beq");
    step(6'd2, 26'h0, 1, 1, "R8 stall jump");
    // move into a high region, then jump must keep the region bits
    step(6'd4, 26'h4000, 1, 0, "R3 far branch");
    for (int i = 0; i < 8; i++) step(6'd4, 26'h7FFF, 1, 0, "R5 climb");
    step(6'd2, 26'h0000_040, 0, 0, "R6 jump keeps region");
    step(6'd3, 26'h0ABCDEF, 1, 0, "R6 jal keeps region");
    for (int i = 0; i < 40; i++)
      step(6'(i % 8), 26'((i * 40503) & 26'h3FFFFFF), i[0], (i % 5 == 0), "R2 mixed");
    doReset();
    step(6'd0, 26'h0, 0, 0, "R2 after reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule